// File: doc/BRIEF.md
# Float to Extended-Precision Converter

This block widens a binary floating-point operand to the 80-bit extended format. That format has a sign bit, a 15-bit exponent biased by 16383, and a 64-bit significand whose top bit is an explicit integer bit. The operand can be single precision, double precision, or already extended. A 2-bit format select names the format. For single and double inputs, the block also flags the two operand exceptions a widening load can raise: an invalid operation for a signalling NaN, and a denormal operand. Widening is exact, so the block does no rounding.

The block registers its output and has one cycle of latency. An operand is taken on any clock edge where `in_valid` is high. One cycle later, `out_valid` rises together with the result and both flags. The block has no multi-cycle state machine. Its only sequential elements are the valid register (states *empty* and *loaded*, with the transitions *accept* on `in_valid`, *drain* otherwise) and the result/flag register, which captures on *accept* and holds on *drain*.

Top module: `fpx_widen`

## Requirements
- R1: A normal single input (format 00, operand bits [31:0]: sign 31, exponent 30:23, fraction 22:0) is rebiased from 127 to 16383. Its integer bit is set to 1 and its fraction is left-aligned below the integer bit.
- R2: A normal double input (format 01, bits [63:0]: sign 63, exponent 62:52, fraction 51:0) is rebiased from 1023 to 16383. Its integer bit is 1 and its fraction is left-aligned.
- R3: An extended input (format 10, all 80 bits: sign 79, exponent 78:64, significand 63:0) appears unchanged on `result`, with both flags low, whatever its encoding.
- R4: A single or double zero keeps its sign and gives exponent 0 and significand 0, with no flags.
- R5: A single or double infinity keeps its sign and gives exponent 0x7FFF and significand 0x8000000000000000, with no flags.
- R6: A single or double NaN gives exponent 0x7FFF, integer bit 1, and its payload left-aligned into the 63-bit fraction, with fraction bit 62 forced to 1. The input is signalling when its top fraction bit is 0. Only a signalling input raises `flag_invalid`.
- R7: A single or double denormal (exponent field 0, fraction non-zero) raises `flag_denormal`. It still yields the exact normalised value: the significand is shifted left until bit 63 is 1, and the exponent is 16383 − bias − (leading zeros of the fraction).
- R8: Format 11 is reserved and gives an all-zero result with no flags. Operand bits above the selected format's width are ignored.
- R9: `out_valid` is `in_valid` delayed by one cycle. The result and flags change only on cycles where `in_valid` was high, and hold otherwise. Reset clears `out_valid`, `result` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| fmt | input | 2 | Format select: 00 single, 01 double, 10 extended, 11 reserved |
| operand | input | 80 | Operand, right-aligned for narrow formats |
| out_valid | output | 1 | Result registered from the previous accepted operand |
| result | output | 80 | Extended-precision value |
| flag_invalid | output | 1 | Signalling-NaN input in single or double format |
| flag_denormal | output | 1 | Denormal input in single or double format |

## Verification
The bench targets the denormal extremes, where the smallest single and double denormals need the longest normalising shift. A wrong leading-zero count or a wrong exponent base would show up there as an off-by-one exponent or a significand without its integer bit.

The bench feeds signalling NaNs with payloads in the lowest fraction bit, so that a design that drops the payload or fails to set the quiet bit gives a wrong significand. Quiet NaNs check that a design testing the wrong bit does not raise a false invalid flag.

Extended operands with an SNaN or denormal pattern check that a design which classifies every format flags nothing and leaves the value untouched. Garbage in the unused upper operand bits would expose a narrow path that reads outside its own width.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_EXT    = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    localparam int EXT_EXP_W = 15;
    localparam int EXT_SIG_W = 64;
    localparam int EXT_W     = 1 + EXT_EXP_W + EXT_SIG_W;
    localparam int EXT_BIAS  = (1 << (EXT_EXP_W - 1)) - 1;

    typedef struct packed {
        logic                 sign;
        logic [EXT_EXP_W-1:0] exp;
        logic [EXT_SIG_W-1:0] sig;
    } ext_t;
endpackage

// File: rtl/fpx_lzc.sv
module fpx_lzc #(
    parameter int W  = 23,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        logic found;
        found = 1'b0;
        count = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found) begin
                if (vec[i]) found = 1'b1;
                else        count = count + CW'(1);
            end
        end
    end
endmodule

// File: rtl/fpx_narrow_to_ext.sv
module fpx_narrow_to_ext
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int IN_W  = 1 + EXP_W + FRAC_W,
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
    localparam int LZ_W  = $clog2(FRAC_W + 1)
) (
    input  logic [IN_W-1:0] src,
    output ext_t            dst,
    output logic            is_snan,
    output logic            is_denorm
);
    localparam logic [EXT_EXP_W-1:0] REBIAS  = EXT_EXP_W'(EXT_BIAS - BIAS);
    localparam logic [EXT_EXP_W-1:0] EXP_TOP = '1;

    logic              s_sign;
    logic [EXP_W-1:0]  s_exp;
    logic [FRAC_W-1:0] s_frac;
    logic [LZ_W-1:0]   s_lz;
    logic [62:0]       frac_al;
    logic [63:0]       den_sig;

    assign s_sign  = src[IN_W-1];
    assign s_exp   = src[FRAC_W +: EXP_W];
    assign s_frac  = src[FRAC_W-1:0];
    assign frac_al = {s_frac, {(63 - FRAC_W){1'b0}}};
    assign den_sig = {s_frac, {(64 - FRAC_W){1'b0}}} << s_lz;

    fpx_lzc #(.W(FRAC_W)) lzc_i (.vec(s_frac), .count(s_lz));

    always_comb begin
        dst       = '0;
        dst.sign  = s_sign;
        is_snan   = 1'b0;
        is_denorm = 1'b0;
        if (&s_exp) begin
            dst.exp = EXP_TOP;
            if (s_frac == '0) begin
                dst.sig = {1'b1, 63'd0};
            end else begin
                dst.sig = {1'b1, frac_al | {1'b1, 62'd0}};
                is_snan = ~s_frac[FRAC_W-1];
            end
        end else if (s_exp == '0) begin
            if (s_frac != '0) begin
                dst.exp   = REBIAS - EXT_EXP_W'(s_lz);
                dst.sig   = den_sig;
                is_denorm = 1'b1;
            end
        end else begin
            dst.exp = EXT_EXP_W'(s_exp) + REBIAS;
            dst.sig = {1'b1, frac_al};
        end
    end
endmodule

// File: rtl/fpx_widen.sv
module fpx_widen
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       fmt,
    input  logic [EXT_W-1:0] operand,
    output logic             out_valid,
    output logic [EXT_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_denormal
);
    localparam int SP_EXP = 8;
    localparam int SP_FRC = 23;
    localparam int DP_EXP = 11;
    localparam int DP_FRC = 52;
    localparam int NARROW_N = 2;

    fmt_e fmt_sel;
    assign fmt_sel = fmt_e'(fmt);

    ext_t narrow_res [NARROW_N];
    logic narrow_snan [NARROW_N];
    logic narrow_den  [NARROW_N];

    for (genvar g = 0; g < NARROW_N; g++) begin : g_narrow
        localparam int EW = (g == 0) ? SP_EXP : DP_EXP;
        localparam int FW = (g == 0) ? SP_FRC : DP_FRC;
        fpx_narrow_to_ext #(.EXP_W(EW), .FRAC_W(FW)) cvt_i (
            .src      (operand[EW+FW:0]),
            .dst      (narrow_res[g]),
            .is_snan  (narrow_snan[g]),
            .is_denorm(narrow_den[g])
        );
    end

    logic [EXT_W-1:0] nxt_res;
    logic             nxt_inv;
    logic             nxt_den;

    always_comb begin
        nxt_res = '0;
        nxt_inv = 1'b0;
        nxt_den = 1'b0;
        unique case (fmt_sel)
            FMT_SINGLE: begin
                nxt_res = narrow_res[0];
                nxt_inv = narrow_snan[0];
                nxt_den = narrow_den[0];
            end
            FMT_DOUBLE: begin
                nxt_res = narrow_res[1];
                nxt_inv = narrow_snan[1];
                nxt_den = narrow_den[1];
            end
            FMT_EXT:  nxt_res = operand;
            FMT_RSVD: nxt_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result        <= '0;
            flag_invalid  <= 1'b0;
            flag_denormal <= 1'b0;
        end else if (in_valid) begin
            result        <= nxt_res;
            flag_invalid  <= nxt_inv;
            flag_denormal <= nxt_den;
        end
    end

    assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(flag_invalid) && $stable(flag_denormal));

    assert_ext_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'b10) |=> (result == $past(operand)) && !flag_invalid && !flag_denormal);

    assert_flags_narrow_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt[1]) |=> !flag_invalid && !flag_denormal);

    assert_invalid_gives_qnan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (result[78:64] == 15'h7FFF) && result[63] && result[62]);

    assert_denorm_normalised_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_denormal |-> result[63] && !flag_invalid);
endmodule

// File: tb/fpx_widen_tb_top.sv
module fpx_widen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [79:0] operand = '0;
    logic        out_valid;
    logic [79:0] result;
    logic        flag_invalid;
    logic        flag_denormal;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    fpx_widen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
        .operand(operand), .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
    );

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic convert(input string req, input logic [1:0] f, input logic [79:0] op,
                           input logic [79:0] exp_res, input logic exp_inv, input logic exp_den);
        @(negedge clk);
        fmt = f; operand = op; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, 80'(out_valid), 80'd1);
        check(req, result, exp_res);
        check(req, {78'd0, flag_invalid, flag_denormal}, {78'd0, exp_inv, exp_den});
    endtask

    task automatic t_reset;
        check("R9 reset", {out_valid, flag_invalid, flag_denormal, 77'd0}, 80'd0);
        check("R9 reset", result, 80'd0);
    endtask

    task automatic t_single_normal;
        convert("R1 1.0", 2'b00, 80'h3F800000, 80'h3FFF_8000000000000000, 0, 0);
        convert("R1 -2.5", 2'b00, 80'hC0200000, 80'hC000_A000000000000000, 0, 0);
    endtask

    task automatic t_double_normal;
        convert("R2 1.0", 2'b01, 80'h3FF0000000000000, 80'h3FFF_8000000000000000, 0, 0);
        convert("R2 -0.75", 2'b01, 80'hBFE8000000000000, 80'hBFFE_C000000000000000, 0, 0);
    endtask

    task automatic t_ext;
        convert("R3 snan pattern", 2'b10, 80'h7FFF_8000000000000001, 80'h7FFF_8000000000000001, 0, 0);
        convert("R3 denorm pattern", 2'b10, 80'h0000_4000000000000001, 80'h0000_4000000000000001, 0, 0);
    endtask

    task automatic t_zero_inf;
        convert("R4 -0 single", 2'b00, 80'h80000000, 80'h8000_0000000000000000, 0, 0);
        convert("R4 +0 double", 2'b01, 80'h0, 80'h0, 0, 0);
        convert("R5 +inf single", 2'b00, 80'h7F800000, 80'h7FFF_8000000000000000, 0, 0);
        convert("R5 -inf double", 2'b01, 80'hFFF0000000000000, 80'hFFFF_8000000000000000, 0, 0);
    endtask

    task automatic t_nan;
        convert("R6 qnan single", 2'b00, 80'h7FC00000, 80'h7FFF_C000000000000000, 0, 0);
        convert("R6 snan single", 2'b00, 80'h7F800001, 80'h7FFF_C000010000000000, 1, 0);
        convert("R6 snan double", 2'b01, 80'h7FF0000000000001, 80'h7FFF_C000000000000800, 1, 0);
    endtask

    task automatic t_denorm;
        convert("R7 min single", 2'b00, 80'h00000001, 80'h3F6A_8000000000000000, 0, 1);
        convert("R7 big single", 2'b00, 80'h80400000, 80'hBF80_8000000000000000, 0, 1);
        convert("R7 min double", 2'b01, 80'h0000000000000001, 80'h3BCD_8000000000000000, 0, 1);
    endtask

    task automatic t_format_edges;
        convert("R8 upper bits ignored", 2'b00, 80'hFFFF_FFFFFFFF_3F800000, 80'h3FFF_8000000000000000, 0, 0);
        convert("R8 reserved fmt", 2'b11, 80'h7F800001, 80'h0, 0, 0);
    endtask

    task automatic t_hold;
        convert("R9 load", 2'b00, 80'h00000001, 80'h3F6A_8000000000000000, 0, 1);
        @(negedge clk);
        fmt = 2'b00; operand = 80'h7F800001;
        @(negedge clk);
        check("R9 idle valid", 80'(out_valid), 80'd0);
        check("R9 hold result", result, 80'h3F6A_8000000000000000);
        check("R9 hold flags", {78'd0, flag_invalid, flag_denormal}, 80'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_normal();
        t_double_normal();
        t_ext();
        t_zero_inf();
        t_nan();
        t_denorm();
        t_format_edges();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule